// File: doc/BRIEF.md
# On-Chip Data Window Access Decoder

This block sits between the CPU's external-data access path and the chip's pins. For every external-data access it decides whether the target is the on-chip data window or the external bus. The on-chip window holds the local RAM and the bus-controller register area. The block also decides whether the multiplexed low and high address/data ports run in bus mode or stay general I/O, and whether the read and write strobes toggle. It also steers read data back to the CPU, taking it from the on-chip array or from the external bus.

An access uses one of two addressing forms. The first is a full 16-bit pointer. The second is an 8-bit register-indirect offset, whose upper address byte comes from a page input. A small control register holds two bits. The first is a window-off bit, set by reset, which software can clear but never set again. The second is a mirror bit, which makes internal accesses show on the external bus with active strobes. The code-fetch mode pin also counts. When code runs from external memory, the ports stay in bus mode even during hidden internal accesses.

Top module: `xram_map_decoder`

## Requirements
- R1: After reset the window-off bit is 1 and the mirror bit is 0, so every access goes to the external bus (selInternal=0).
- R2: A 16-bit pointer access hits the window when the pointer is at least F700h and the window-off bit is 0. F6FFh misses, and F700h and FFFFh hit.
- R3: An 8-bit access uses address {accPage, accReg}, so it hits the window exactly when accPage is F7h or above. The 16-bit pointer value is ignored for it.
- R4: A control write carries the window-off value in cfgWdata bit 0 and the mirror value in bit 1. Writing 0 to bit 0 clears window-off, and writing 1 to it is dropped once it is clear. Only reset sets it again. The mirror bit takes any written value.
- R5: A window hit with mirror=0 keeps rdStrobe and wrStrobe low.
- R6: A window hit with mirror=1 raises the strobe for its direction and puts port 0 in bus mode. Port 2 also goes to bus mode for a 16-bit access.
- R7: A miss, or any access while window-off is 1, raises the strobe for its direction (rdStrobe when accWrite=0, wrStrobe when accWrite=1). It puts port 0 in bus mode, and port 2 as well for a 16-bit access.
- R8: During an 8-bit access port2Bus is 0 (port 2 stays general I/O).
- R9: A hidden window hit (mirror=0) with eaPin=0 (external code) keeps port 0 in bus mode, and port 2 as well for a 16-bit access. With eaPin=1 both ports stay general I/O.
- R10: cpuRdData equals intRdData on a window hit, even when the hit is mirrored. Otherwise it equals extRdData.
- R11: With accReq=0, selInternal, port0Bus, port2Bus, rdStrobe and wrStrobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | 2 | Bit 0 window-off, bit 1 mirror |
| eaPin | input | 1 | 1 = code from on-chip ROM, 0 = external code |
| accReq | input | 1 | External-data access in progress |
| accWrite | input | 1 | 1 = write, 0 = read |
| accByte | input | 1 | 1 = 8-bit register-indirect form |
| accPtr | input | 16 | 16-bit pointer address |
| accReg | input | 8 | 8-bit indirect offset |
| accPage | input | 8 | Page supplying upper address byte |
| intRdData | input | 8 | Read data from on-chip window |
| extRdData | input | 8 | Read data from external bus |
| selInternal | output | 1 | Access targets on-chip window |
| port0Bus | output | 1 | Port 0 in address/data bus mode |
| port2Bus | output | 1 | Port 2 in high-address bus mode |
| rdStrobe | output | 1 | External read strobe active |
| wrStrobe | output | 1 | External write strobe active |
| cpuRdData | output | 8 | Read data returned to CPU |

## Verification
Every decode output and the read-data mux depend on the access inputs through logic alone, so their results are due in the same cycle the access is driven. The bench drives on the falling edge and samples a few nanoseconds later, before the next rising edge. A control write is registered, so its effect first appears after the next rising edge. The bench holds cfgWe for one full cycle, drops it on the falling edge, and only then presents the access it checks. A reset pulse in the middle of the run confirms that the window-off bit comes back only through reset.

// File: rtl/xmap_pkg.sv
package xmap_pkg;
  // Strobes from control to datapath / top outputs
  typedef struct packed {
    logic selInt;
    logic p0Bus;
    logic p2Bus;
    logic rdEn;
    logic wrEn;
  } xmap_ctl_t;
endpackage

// File: rtl/xmap_cfg_reg.sv
module xmap_cfg_reg (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgWdata,
  output logic       xmapOff,
  output logic       mirrorOn
);
  localparam int OFF_BIT = 0;
  localparam int MIR_BIT = 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xmapOff  <= 1'b1;
      mirrorOn <= 1'b0;
    end else if (cfgWe) begin
      mirrorOn <= cfgWdata[MIR_BIT];
      // one-way: only a clear is accepted
      if (!cfgWdata[OFF_BIT]) xmapOff <= 1'b0;
    end
  end
endmodule

// File: rtl/xmap_datapath.sv
module xmap_datapath
  import xmap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF700
) (
  input  logic              accByte,
  input  logic [ADDR_W-1:0] accPtr,
  input  logic [REG_W-1:0]  accReg,
  input  logic [ADDR_W-REG_W-1:0] accPage,
  input  logic [DATA_W-1:0] intRdData,
  input  logic [DATA_W-1:0] extRdData,
  input  xmap_ctl_t         ctl,
  output logic              winHit,
  output logic [DATA_W-1:0] cpuRdData
);
  logic [ADDR_W-1:0] effAddr;

  always_comb begin
    effAddr   = accByte ? {accPage, accReg} : accPtr;
    winHit    = (effAddr >= WIN_BASE);
    cpuRdData = ctl.selInt ? intRdData : extRdData;
  end
endmodule

// File: rtl/xmap_control.sv
module xmap_control
  import xmap_pkg::*;
(
  input  logic      accReq,
  input  logic      accWrite,
  input  logic      accByte,
  input  logic      eaPin,
  input  logic      winHit,
  input  logic      xmapOff,
  input  logic      mirrorOn,
  output xmap_ctl_t ctl
);
  logic inWin;
  logic visible;
  logic portsBus;

  always_comb begin
    inWin    = winHit && !xmapOff;
    visible  = !inWin || mirrorOn;
    portsBus = visible || !eaPin;
    ctl.selInt = accReq && inWin;
    ctl.p0Bus  = accReq && portsBus;
    ctl.p2Bus  = accReq && !accByte && portsBus;
    ctl.rdEn   = accReq && visible && !accWrite;
    ctl.wrEn   = accReq && visible && accWrite;
  end
endmodule

// File: rtl/xram_map_decoder.sv
module xram_map_decoder
  import xmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF700
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgWdata,
  input  logic              eaPin,
  input  logic              accReq,
  input  logic              accWrite,
  input  logic              accByte,
  input  logic [ADDR_W-1:0] accPtr,
  input  logic [REG_W-1:0]  accReg,
  input  logic [ADDR_W-REG_W-1:0] accPage,
  input  logic [DATA_W-1:0] intRdData,
  input  logic [DATA_W-1:0] extRdData,
  output logic              selInternal,
  output logic              port0Bus,
  output logic              port2Bus,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic [DATA_W-1:0] cpuRdData
);
  logic      xmapOff;
  logic      mirrorOn;
  logic      winHit;
  xmap_ctl_t ctl;

  xmap_cfg_reg u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .xmapOff(xmapOff), .mirrorOn(mirrorOn)
  );

  xmap_control u_ctl (
    .accReq(accReq), .accWrite(accWrite), .accByte(accByte), .eaPin(eaPin),
    .winHit(winHit), .xmapOff(xmapOff), .mirrorOn(mirrorOn), .ctl(ctl)
  );

  xmap_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .WIN_BASE(WIN_BASE)
  ) u_dp (
    .accByte(accByte), .accPtr(accPtr), .accReg(accReg), .accPage(accPage),
    .intRdData(intRdData), .extRdData(extRdData), .ctl(ctl),
    .winHit(winHit), .cpuRdData(cpuRdData)
  );

  assign selInternal = ctl.selInt;
  assign port0Bus    = ctl.p0Bus;
  assign port2Bus    = ctl.p2Bus;
  assign rdStrobe    = ctl.rdEn;
  assign wrStrobe    = ctl.wrEn;
endmodule

// File: rtl/xmap_checker.sv
module xmap_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              xmapOff,
  input logic              mirrorOn,
  input logic              accReq,
  input logic              accByte,
  input logic              selInternal,
  input logic              port0Bus,
  input logic              port2Bus,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic [DATA_W-1:0] intRdData,
  input logic [DATA_W-1:0] cpuRdData
);
  // R4: once cleared, window-off stays clear until reset
  a_r4_one_way: assert property (@(posedge clk) disable iff (!rstN)
    !xmapOff |=> !xmapOff);

  // R1: window-off forces external target
  a_r1_off_external: assert property (@(posedge clk) disable iff (!rstN)
    xmapOff |-> !selInternal);

  // R5: hidden internal access keeps strobes quiet
  a_r5_hidden_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (selInternal && !mirrorOn) |-> (!rdStrobe && !wrStrobe));

  // R7: external access drives port 0 with one strobe
  a_r7_external_bus: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && !selInternal) |-> (port0Bus && $countones({rdStrobe, wrStrobe}) == 1));

  // R8: 8-bit form leaves port 2 as I/O
  a_r8_byte_p2_io: assert property (@(posedge clk) disable iff (!rstN)
    (accReq && accByte) |-> !port2Bus);

  // R10: internal data wins on a hit
  a_r10_int_data: assert property (@(posedge clk) disable iff (!rstN)
    selInternal |-> (cpuRdData == intRdData));

  // R11: idle bus
  a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
    !accReq |-> !(selInternal || port0Bus || port2Bus || rdStrobe || wrStrobe));
endmodule

bind xram_map_decoder xmap_checker #(.DATA_W(DATA_W)) u_xmap_chk (
  .clk(clk), .rstN(rstN), .xmapOff(xmapOff), .mirrorOn(mirrorOn),
  .accReq(accReq), .accByte(accByte), .selInternal(selInternal),
  .port0Bus(port0Bus), .port2Bus(port2Bus), .rdStrobe(rdStrobe),
  .wrStrobe(wrStrobe), .intRdData(intRdData), .cpuRdData(cpuRdData)
);

// File: tb/xram_map_decoder_bench.sv
module xram_map_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgWdata = 2'b00;
  logic        eaPin = 1'b1;
  logic        accReq = 1'b0;
  logic        accWrite = 1'b0;
  logic        accByte = 1'b0;
  logic [15:0] accPtr = '0;
  logic [7:0]  accReg = '0;
  logic [7:0]  accPage = '0;
  logic [7:0]  intRdData = 8'hA5;
  logic [7:0]  extRdData = 8'h3C;
  logic        selInternal, port0Bus, port2Bus, rdStrobe, wrStrobe;
  logic [7:0]  cpuRdData;

  int errors = 0;
  int checks = 0;

  xram_map_decoder u_xram_map_decoder (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .eaPin(eaPin),
    .accReq(accReq), .accWrite(accWrite), .accByte(accByte), .accPtr(accPtr),
    .accReg(accReg), .accPage(accPage), .intRdData(intRdData),
    .extRdData(extRdData), .selInternal(selInternal), .port0Bus(port0Bus),
    .port2Bus(port2Bus), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .cpuRdData(cpuRdData)
  );

  always #10 clk = ~clk;

  // vector: mirror, ea, byte, write, ptr[16], reg[8], page[8], exp{sel,p0,p2,rd,wr}
  localparam int NV = 12;
  localparam logic [40:0] TBL [NV] = '{
    {1'b0,1'b1,1'b0,1'b0,16'hF700,8'h00,8'h00,5'b10000}, // R2 R5 R9 base hit
    {1'b0,1'b1,1'b0,1'b0,16'hF6FF,8'h00,8'h00,5'b01110}, // R2 R7 miss
    {1'b0,1'b1,1'b0,1'b1,16'hFFFF,8'h00,8'h00,5'b10000}, // R2 R5 top hit write
    {1'b0,1'b0,1'b0,1'b0,16'hFFFF,8'h00,8'h00,5'b11100}, // R9 ext code 16-bit
    {1'b0,1'b0,1'b1,1'b0,16'h0000,8'h00,8'hF7,5'b11000}, // R3 R8 R9 byte page F7
    {1'b0,1'b1,1'b1,1'b1,16'hFFFF,8'hFF,8'hF6,5'b01001}, // R3 R7 R8 page F6 miss
    {1'b0,1'b1,1'b1,1'b0,16'h0000,8'h80,8'hFF,5'b10000}, // R3 hidden byte hit
    {1'b1,1'b1,1'b0,1'b0,16'hF800,8'h00,8'h00,5'b11110}, // R6 mirrored read
    {1'b1,1'b1,1'b1,1'b1,16'h0000,8'h10,8'hF8,5'b11001}, // R6 R8 mirrored byte write
    {1'b1,1'b0,1'b0,1'b1,16'h1234,8'h00,8'h00,5'b01101}, // R7 external write
    {1'b0,1'b1,1'b0,1'b0,16'h0000,8'h00,8'h00,5'b01110}, // R7 low address
    {1'b0,1'b1,1'b1,1'b0,16'hF800,8'h00,8'h00,5'b01010}  // R3 ptr ignored in byte form
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic access(input logic ea, input logic byt, input logic wr,
                        input logic [15:0] ptr, input logic [7:0] rg, input logic [7:0] pg);
    @(negedge clk);
    eaPin = ea; accByte = byt; accWrite = wr; accPtr = ptr; accReg = rg;
    accPage = pg; accReq = 1'b1;
    #2;
  endtask

  function automatic logic [4:0] outs();
    return {selInternal, port0Bus, port2Bus, rdStrobe, wrStrobe};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 idle outputs
    #2 chk("R11 idle", {3'b0, outs()}, 8'h00);
    // R1 reset state: everything external
    access(1'b1, 1'b0, 1'b0, 16'hF800, 8'h00, 8'h00);
    chk("R1 reset external", {3'b0, outs()}, {3'b0, 5'b01110});
    chk("R1 R10 ext data", cpuRdData, 8'h3C);
    // R4 mirror writable while window still off: mirror only, stays external
    cfgWrite(2'b11);
    access(1'b1, 1'b0, 1'b0, 16'hF800, 8'h00, 8'h00);
    chk("R4 set keeps off", {7'b0, selInternal}, 8'h00);
    // enable window
    cfgWrite(2'b00);
    for (int i = 0; i < NV; i++) begin
      cfgWrite({TBL[i][40], 1'b0});
      access(TBL[i][39], TBL[i][38], TBL[i][37], TBL[i][36:21], TBL[i][20:13], TBL[i][12:5]);
      chk($sformatf("vector %0d R2/R3/R5-R9", i), {3'b0, outs()}, {3'b0, TBL[i][4:0]});
      chk($sformatf("vector %0d R10", i), cpuRdData, TBL[i][4] ? 8'hA5 : 8'h3C);
    end
    // R4 write 1 to bit 0 is dropped
    cfgWrite(2'b01);
    access(1'b1, 1'b0, 1'b0, 16'hF800, 8'h00, 8'h00);
    chk("R4 set dropped", {3'b0, outs()}, {3'b0, 5'b10000});
    // R10 internal data tracks intRdData on mirrored hit
    cfgWrite(2'b10);
    intRdData = 8'h5E;
    access(1'b1, 1'b0, 1'b0, 16'hF700, 8'h00, 8'h00);
    chk("R10 mirrored int data", cpuRdData, 8'h5E);
    chk("R6 mirrored strobe", {3'b0, outs()}, {3'b0, 5'b11110});
    // R11 idle after enable
    @(negedge clk); accReq = 1'b0; #2;
    chk("R11 idle enabled", {3'b0, outs()}, 8'h00);
    // R4 only reset restores window-off
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(1'b1, 1'b1, 1'b0, 16'h0000, 8'h00, 8'hF9);
    chk("R4 R1 reset restores off", {3'b0, outs()}, {3'b0, 5'b01010});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule